// File: doc/BRIEF.md
# DMA Transfer Byte Counter with Staged Reload

This block keeps the byte count for DMA transfers in a bus-interface controller. The host writes a low and a high count byte into a staging copy. A live counter, which the host can read back, takes the staged value only when the host issues a command with the DMA flag set. Commands without that flag run in programmed-I/O mode and leave the counter and the DMA port alone.

A DMA transfer command works out its length from two limits. One is the live count, where a programmed zero stands for 65536 bytes. The other is the number of bytes the current bus phase still has, or a fixed 32-byte limit while the controller is collecting a command. The block then presents a ready/valid byte port and lowers the live count by one for each byte the memory side accepts. When the last byte is accepted, or at once if the length is zero, it pulses a done strobe and raises an interrupt. At the same time it sets terminal count, loads the interrupt register with the bus-service code and clears the counter to zero.

Top module: `tc_xfer_counter`

## Requirements
- R1: After reset, offsets 0, 1, 4 and 5 read 0x00, and dma_valid, xfer_done and irq are low.
- R2: A host write to offset 0 (count bits 7:0) or offset 1 (count bits 15:8) changes only the staging copy. The live count read at offsets 0 and 1 keeps its value.
- R3: A host write to offset 0 or 1 clears the terminal-count flag, which is status bit 4 at offset 4.
- R4: A command write to offset 3 with bit 7 set copies the staged count into the live count. With bit 7 clear, the live count is not changed and no transfer starts.
- R5: A command of 0x90 (bit 7 set, low seven bits 0x10) starts a transfer. The number of bytes accepted is the smaller of the count (0 means 65536) and phase_left. When collect_mode is high, the limit is 32 instead of phase_left.
- R6: The live count drops by one for each byte accepted (dma_valid and dma_ready both high at a clock edge). It holds while dma_ready is low.
- R7: At completion, xfer_done is high for exactly one cycle and irq rises in that same cycle. Status reads 0x90 (bit 7 is the interrupt flag, bit 4 is terminal count), offset 5 reads 0x10, and the live count reads zero. A zero-length transfer completes in the cycle after the command.
- R8: Starting a transfer of nonzero length clears terminal count and raises dma_valid in the cycle after the command write.
- R9: A read of offset 5 with host_rd high returns the interrupt code and then clears that register and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; side effects only at offset 5 |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| collect_mode | input | 1 | Command-collect phase; caps length at 32 |
| phase_left | input | 17 | Bytes remaining in the current bus phase |
| dma_valid | output | 1 | Byte port has a transfer pending |
| dma_ready | input | 1 | Memory side accepts a byte this cycle |
| xfer_done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume the host issues no write to offsets 0, 1 or 3 while a transfer is running. They also assume collect_mode and phase_left are stable in the cycle of a command write. The bench keeps to both: it issues every command only after the previous completion pulse has been seen, and it changes collect_mode and phase_left only between transfers. dma_ready is driven freely, including long stalls, because the design must tolerate any pattern there.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam logic [2:0] A_CNT_LO = 3'd0;
  localparam logic [2:0] A_CMD    = 3'd3;
  localparam logic [2:0] A_STAT   = 3'd4;
  localparam logic [2:0] A_INTR   = 3'd5;
  localparam int DMA_FLAG_BIT = 7;
  localparam logic [6:0] OP_XFER  = 7'h10;
  localparam logic [7:0] INTR_SERVICE = 8'h10;
  localparam int ST_TC_BIT  = 4;
  localparam int ST_IRQ_BIT = 7;

  // Effective length: count (zero meaning full range) clamped by the active bound
  function automatic logic [31:0] tc_xfer_len(input logic [31:0] cnt, input int unsigned cw,
                                              input logic collect, input logic [31:0] phase,
                                              input logic [31:0] lim);
    logic [31:0] eff;
    logic [31:0] bound;
    eff   = (cnt == 32'd0) ? (32'd1 << cw) : cnt;
    bound = collect ? lim : phase;
    return (eff < bound) ? eff : bound;
  endfunction
endpackage

// File: rtl/tc_host_if.sv
module tc_host_if
  import tc_pkg::*;
#(
  parameter int BW = 8,
  parameter int NB = 2,
  localparam int CW = BW * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic [2:0]    host_addr,
  input  logic [BW-1:0] host_wdata,
  input  logic          busy,
  output logic [CW-1:0] stage,
  output logic          cnt_wr,
  output logic          reload,
  output logic          start
);
  logic [NB-1:0] lane_wr;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane_wr[g] = host_wr && (host_addr == 3'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) stage[g*BW +: BW] <= '0;
      else if (lane_wr[g]) stage[g*BW +: BW] <= host_wdata;
    end
  end

  logic cmd_wr;
  assign cmd_wr = host_wr && (host_addr == A_CMD) && !busy;
  assign cnt_wr = |lane_wr;
  assign reload = cmd_wr && host_wdata[DMA_FLAG_BIT];
  assign start  = reload && (host_wdata[6:0] == OP_XFER);

  // R4: the non-DMA command path never produces a reload
  a_r4_no_reload_pio: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_CMD && !host_wdata[DMA_FLAG_BIT]) |-> !reload && !start);
endmodule

// File: rtl/tc_engine.sv
module tc_engine
  import tc_pkg::*;
#(
  parameter int CW = 16,
  parameter int LIMIT = 32,
  localparam int PW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload,
  input  logic          start,
  input  logic [CW-1:0] stage,
  input  logic          collect,
  input  logic [PW-1:0] phase_left,
  input  logic          ready,
  output logic          valid,
  output logic [CW-1:0] live,
  output logic          fin,
  output logic          done
);
  localparam logic [PW-1:0] ONE_P = PW'(1);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [PW-1:0] remain;
  logic [31:0]   len_full;
  logic [PW-1:0] len;
  logic          accept;

  assign len_full = tc_xfer_len(32'(stage), CW, collect, 32'(phase_left), 32'(LIMIT));
  assign len      = len_full[PW-1:0];
  assign accept   = valid && ready;
  assign fin      = (start && len == '0) || (accept && remain == ONE_P);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      remain <= '0;
      live   <= '0;
      done   <= 1'b0;
    end else begin
      done <= fin;
      if (reload) live <= stage;
      if (start) begin
        valid  <= (len != '0);
        remain <= len;
      end else if (accept) begin
        remain <= remain - ONE_P;
        live   <= live - ONE_C;
        if (remain == ONE_P) valid <= 1'b0;
      end
      if (fin) live <= '0;
    end
  end

  a_r6_dec_per_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && remain != ONE_P) |=> live == $past(live) - ONE_C);
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> $stable(live) && valid);
  a_r7_zero_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> live == '0 && !valid);
  a_r5_collect_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (start && collect) |=> remain <= PW'(LIMIT));
endmodule

// File: rtl/tc_status.sv
module tc_status
  import tc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fin,
  input  logic       start,
  input  logic       cnt_wr,
  input  logic       intr_rd,
  output logic       tc,
  output logic       irq,
  output logic [7:0] intr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc   <= 1'b0;
      irq  <= 1'b0;
      intr <= '0;
    end else begin
      if (fin) tc <= 1'b1;
      else if (start || cnt_wr) tc <= 1'b0;
      if (fin) begin
        irq  <= 1'b1;
        intr <= INTR_SERVICE;
      end else if (intr_rd) begin
        irq  <= 1'b0;
        intr <= '0;
      end
    end
  end

  a_r7_flags_set: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> tc && irq && intr == INTR_SERVICE);
  a_r3_tc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !fin) |=> !tc);
  a_r8_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !fin) |=> !tc);
  a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_rd && !fin) |=> !irq && intr == '0);
endmodule

// File: rtl/tc_xfer_counter.sv
module tc_xfer_counter
  import tc_pkg::*;
#(
  parameter int BW = 8,
  parameter int NB = 2,
  parameter int COLLECT_LIMIT = 32,
  localparam int CW = BW * NB,
  localparam int PW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [2:0]    host_addr,
  input  logic [BW-1:0] host_wdata,
  output logic [BW-1:0] host_rdata,
  input  logic          collect_mode,
  input  logic [PW-1:0] phase_left,
  output logic          dma_valid,
  input  logic          dma_ready,
  output logic          xfer_done,
  output logic          irq
);
  logic [CW-1:0] stage, live;
  logic cnt_wr, reload, start, fin, tc, intr_rd;
  logic [7:0] intr;

  assign intr_rd = host_rd && (host_addr == A_INTR);

  tc_host_if #(.BW(BW), .NB(NB)) u_host (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .busy(dma_valid), .stage(stage),
    .cnt_wr(cnt_wr), .reload(reload), .start(start));

  tc_engine #(.CW(CW), .LIMIT(COLLECT_LIMIT)) u_eng (
    .clk(clk), .rst_n(rst_n), .reload(reload), .start(start), .stage(stage),
    .collect(collect_mode), .phase_left(phase_left), .ready(dma_ready),
    .valid(dma_valid), .live(live), .fin(fin), .done(xfer_done));

  tc_status u_stat (
    .clk(clk), .rst_n(rst_n), .fin(fin), .start(start), .cnt_wr(cnt_wr),
    .intr_rd(intr_rd), .tc(tc), .irq(irq), .intr(intr));

  always_comb begin
    host_rdata = '0;
    if (int'(host_addr) < NB) host_rdata = live[int'(host_addr)*BW +: BW];
    else if (host_addr == A_STAT) begin
      host_rdata[ST_TC_BIT]  = tc;
      host_rdata[ST_IRQ_BIT] = irq;
    end else if (host_addr == A_INTR) host_rdata = BW'(intr);
  end

  a_r7_done_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> irq && !dma_valid);
  a_r1_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_valid && !start) |=> !dma_valid);
endmodule

// File: tb/sim_tc_xfer_counter.sv
module sim_tc_xfer_counter;
  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0;
  logic [2:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic collect_mode = 0;
  logic [16:0] phase_left = 0;
  logic dma_valid, dma_ready = 0, xfer_done, irq;

  int tests = 0, fails = 0;
  int acc = 0, dcnt = 0, cyc = 0, rmode = 0;
  bit irq_bad = 0;

  always #10 clk = ~clk;

  tc_xfer_counter u0 (.clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .collect_mode(collect_mode), .phase_left(phase_left), .dma_valid(dma_valid),
    .dma_ready(dma_ready), .xfer_done(xfer_done), .irq(irq));

  // Ready driver and byte/pulse monitor; ready set here holds until the next negedge
  always @(negedge clk) begin
    cyc++;
    dma_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 3 != 0) : 1'b0;
    if (dma_valid && dma_ready) acc++;
    if (xfer_done) begin
      dcnt++;
      if (!irq) irq_bad = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input bit clr, output int v);
    @(negedge clk); host_addr = a; host_rd = clr; #1 v = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic rd_count(output int v);
    int lo, hi;
    rd(3'd0, 0, lo); rd(3'd1, 0, hi);
    v = hi * 256 + lo;
  endtask

  function automatic int model_len(int c, bit col, int ph);
    int eff;
    eff = (c == 0) ? 65536 : c;
    if (col) ph = 32;
    return (eff < ph) ? eff : ph;
  endfunction

  task automatic wait_done();
    int g = 0;
    while (dcnt == 0 && g < 150000) begin @(negedge clk); g++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_checks(input int exp);
    int v;
    chk(acc == exp, "R5 bytes accepted", acc, exp);
    chk(dcnt == 1, "R7 done pulse count", dcnt, 1);
    chk(!irq_bad, "R7 irq with done", irq_bad, 0);
    rd_count(v); chk(v == 0, "R7 count zero", v, 0);
    rd(3'd4, 0, v); chk(v == 8'h90, "R7 status", v, 8'h90);
    rd(3'd5, 1, v); chk(v == 8'h10, "R7 intr code", v, 8'h10);
    rd(3'd4, 0, v); chk(v == 8'h10 && !irq, "R9 irq cleared", v, 8'h10);
    rd(3'd5, 0, v); chk(v == 0, "R9 intr cleared", v, 0);
  endtask

  task automatic run_one(input int c, input bit col, input int ph, input int rm);
    int v, exp;
    exp = model_len(c, col, ph);
    rmode = rm; collect_mode = col; phase_left = 17'(ph);
    wr(3'd0, 8'(c)); rd(3'd4, 0, v);
    chk(v[4] == 0, "R3 tc cleared by count write", v[4], 0);
    wr(3'd1, 8'(c >> 8));
    rd_count(v); chk(v == 0, "R2 staging only", v, 0);
    acc = 0;
    wr(3'd3, 8'h10); repeat (2) @(negedge clk);
    rd_count(v);
    chk(v == 0 && acc == 0 && !dma_valid, "R4 no reload on PIO command", v, 0);
    wr(3'd3, 8'h80); rd_count(v);
    chk(v == (c & 16'hFFFF), "R4 reload on DMA command", v, c & 16'hFFFF);
    acc = 0; dcnt = 0; irq_bad = 0;
    wr(3'd3, 8'h90);
    host_addr = 3'd4; #1;
    if (exp > 0) chk(dma_valid && host_rdata[4] == 0, "R8 start", dma_valid, 1);
    else chk(!dma_valid && dcnt == 1, "R7 zero length immediate", dcnt, 1);
    wait_done();
    finish_checks(exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v;
    int counts[10] = '{0, 1, 2, 3, 31, 32, 33, 100, 291, 511};
    int phases[5]  = '{0, 1, 7, 40, 300};
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(3'd0, 0, v); chk(v == 0, "R1 count lo", v, 0);
    rd(3'd1, 0, v); chk(v == 0, "R1 count hi", v, 0);
    rd(3'd4, 0, v); chk(v == 0, "R1 status", v, 0);
    rd(3'd5, 0, v); chk(v == 0, "R1 intr", v, 0);
    chk(!dma_valid && !irq && !xfer_done, "R1 outputs idle", dma_valid, 0);

    for (int col = 0; col < 2; col++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 5; j++)
          run_one(counts[i], col[0], phases[j], (i + j) % 2);

    // R6: decrement tracking with stalls
    rmode = 2; collect_mode = 0; phase_left = 17'd300;
    wr(3'd0, 8'd100); wr(3'd1, 8'd0);
    acc = 0; dcnt = 0; irq_bad = 0;
    wr(3'd3, 8'h90);
    repeat (3) @(negedge clk);
    rd_count(v); chk(v == 100, "R6 hold while stalled", v, 100);
    rmode = 1; repeat (20) @(negedge clk);
    rmode = 2; repeat (2) @(negedge clk);
    rd_count(v); chk(v == 100 - acc, "R6 one per byte", v, 100 - acc);
    rmode = 0; wait_done();
    finish_checks(100);

    // R5: programmed zero means 65536 bytes
    run_one(0, 0, 70000, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule